// File: doc/BRIEF.md
# SCSI Target Phase Sequencer

This block plays the target (disk) side of a parallel SCSI bus at the level of bus phases. It watches the lines the initiator drives (reset, select, busy, attention, acknowledge and the data byte), takes part in selection, and then steps the bus through command, data, status and message phases. It drives the phase lines MSG, C/D and I/O, the REQ line and its own BSY. One step of the phase machine is taken on each clock edge.

Command blocks of 6 or 10 bytes are collected one byte per REQ/ACK handshake. The first byte decides the command group, and with it both the block length and whether the command ends in a data-in phase, a data-out phase or straight in status. The byte count is taken from the command block. Data bytes move one at a time with a DRQ/DACK handshake while DMA is enabled. Data-in bytes come from an external byte-read port whose address is the block address times 512 plus the running byte offset. Data-out bytes are counted and then dropped. A command the block does not know still ends cleanly, with a check-condition status, so the bus cannot hang.

Top module: `scsi_target_sequencer`

## Requirements
- R1: A high `busRst` at a clock edge puts the sequencer in bus free, with `tgtBsy`, `reqOut`, `drqOut` and the three phase lines low, whatever else is driven. While it is held, selection cannot start.
- R2: With `selIn` high, `dataEnIn` high, `bsyIn` low and `dataIn[6]` set, `tgtBsy` rises on the second clock edge after `selIn` rises. If `dataIn[6]` is clear, `tgtBsy` stays low.
- R3: If `atnIn` is high when selection completes, the next phase is message-out with MSG=1, C/D=1, I/O=0 and REQ high. One REQ/ACK byte then leads to command phase with MSG=0, C/D=1, I/O=0. Without attention, command phase is entered directly.
- R4: In command phase REQ rises while ACK is low. A cycle with REQ and ACK both high stores `dataIn` as the next command byte and drops REQ on that edge.
- R5: These opcodes are decoded after 6 bytes. 0x00 goes to status. 0x03, 0x12 and 0x1A go to data-in (MSG=0, C/D=0, I/O=1) for byte-4 bytes. 0x15 goes to data-out (all three lines low) for byte-4 bytes.
- R6: Opcode 0x08 after 6 bytes reads byte-4 × 512 bytes from block 0. Opcode 0x28 after 10 bytes reads ({byte 7, byte 8}) × 512 bytes, starting at the block whose address is bytes 2..5, most significant first. `srcAddr` equals block × 512 + byte offset.
- R7: Opcode 0x25 after 10 bytes goes to data-in for exactly 8 bytes.
- R8: In a data phase `drqOut` is raised only while `dmaEn` is high, and `dataOut` then holds the current byte. A DACK seen while DRQ is high completes one byte and drops DRQ. Completing the last byte enters status (MSG=0, C/D=1, I/O=1).
- R9: Status presents its status byte with REQ. After ACK the sequencer moves to message-in (MSG=1, C/D=1, I/O=1) and presents 0x00. After that ACK, `tgtBsy` and the phase lines go low.
- R10: An unknown opcode ends the command in status with byte 0x02. Groups 1 and 2 (opcode bits 7:5 = 1 or 2) are ended after 10 bytes, every other group after 6.
- R11: A data command whose byte count is zero goes straight to status with byte 0x00.
- R12: `srcRd` is never high outside a data-in phase, so data-out bytes never touch the source port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous chip reset, active low |
| busRst | input | 1 | Bus reset line from the initiator |
| selIn | input | 1 | Select line from the initiator |
| bsyIn | input | 1 | Busy line as driven by the initiator |
| atnIn | input | 1 | Attention line from the initiator |
| ackIn | input | 1 | Acknowledge line from the initiator |
| dataEnIn | input | 1 | Initiator is driving the data bus |
| dataIn | input | 8 | Data bus byte from the initiator |
| dmaEn | input | 1 | DMA transfers enabled |
| dackIn | input | 1 | DMA acknowledge for the presented byte |
| srcData | input | 8 | Byte returned by the data source for `srcAddr` |
| tgtBsy | output | 1 | Target busy |
| msgOut | output | 1 | MSG phase line |
| cdOut | output | 1 | C/D phase line |
| ioOut | output | 1 | I/O phase line |
| reqOut | output | 1 | Request line |
| drqOut | output | 1 | DMA request |
| dataOut | output | 8 | Byte presented by the target |
| srcRd | output | 1 | Data source read strobe |
| srcAddr | output | 41 | Data source byte address |

## Verification
The hardest state to reach from the ports is the far end of a long block read, where the byte counter and the offset have crossed several carry boundaries and the block address uses its top byte. The bench reaches it by driving complete 10-byte read commands with a block address whose upper byte is nonzero, then acknowledging all 512 DMA bytes while it compares each one with an address-derived pattern that mixes the low, block and top address bits. A bus reset in the middle of a transfer, with selection held active during it, is produced the same way after a partial transfer.

// File: rtl/scsi_tgt_pkg.sv
package scsi_tgt_pkg;

  typedef enum logic [3:0] {
    PH_FREE,
    PH_ARB,
    PH_SELECT,
    PH_MSG_OUT,
    PH_CMD,
    PH_DATA_IN,
    PH_DATA_OUT,
    PH_STATUS,
    PH_MSG_IN
  } phase_e;

  typedef enum logic [1:0] {
    NX_STATUS,
    NX_DATA_IN,
    NX_DATA_OUT
  } nextKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrLen;
    logic pushByte;
    logic loadXfer;
    logic stepXfer;
    logic showSrc;
    logic showStatus;
    logic showZero;
  } dpCtl_t;

  localparam logic [7:0] ST_GOOD  = 8'h00;
  localparam logic [7:0] ST_CHECK = 8'h02;

  localparam logic [7:0] OP_UNIT_READY = 8'h00;
  localparam logic [7:0] OP_SENSE      = 8'h03;
  localparam logic [7:0] OP_READ_SHORT = 8'h08;
  localparam logic [7:0] OP_IDENTIFY   = 8'h12;
  localparam logic [7:0] OP_PAGE_SET   = 8'h15;
  localparam logic [7:0] OP_PAGE_GET   = 8'h1A;
  localparam logic [7:0] OP_SIZE       = 8'h25;
  localparam logic [7:0] OP_READ_LONG  = 8'h28;

endpackage

// File: rtl/scsi_tgt_dpath.sv
module scsi_tgt_dpath
  import scsi_tgt_pkg::*;
#(
  parameter int LBA_W     = 32,
  parameter int BLK_SHIFT = 9,
  parameter int CMD_MAX   = 10,
  parameter int CNT_W     = 16 + BLK_SHIFT,
  parameter int ADDR_W    = LBA_W + BLK_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [7:0]        dataIn,
  input  logic [7:0]        srcData,
  output logic              decReady,
  output nextKind_e         decKind,
  output logic              cntLast,
  output logic [7:0]        dataOut,
  output logic [ADDR_W-1:0] srcAddr
);

  localparam int LEN_W = $clog2(CMD_MAX + 1);

  logic [7:0]       cmdBuf [CMD_MAX];
  logic [LEN_W-1:0] cmdLen;
  logic [CNT_W-1:0] cntRem;
  logic [CNT_W-1:0] byteOfs;
  logic [LBA_W-1:0] blkAddr;
  logic [7:0]       statusByte;
  logic [7:0]       dataReg;

  logic [7:0]       opcode;
  logic [2:0]       opGroup;
  logic             at6;
  logic             at10;
  nextKind_e        kindRaw;
  logic [7:0]       decStatus;
  logic [CNT_W-1:0] decCount;
  logic [LBA_W-1:0] decLba;

  // command decode on the captured block
  always_comb begin
    opcode    = cmdBuf[0];
    opGroup   = opcode[7:5];
    at6       = (cmdLen == LEN_W'(6)) && (opGroup != 3'd1) && (opGroup != 3'd2);
    at10      = (cmdLen == LEN_W'(10));
    decReady  = at6 || at10;
    kindRaw   = NX_STATUS;
    decStatus = ST_CHECK;
    decCount  = '0;
    decLba    = '0;
    if (at6) begin
      case (opcode)
        OP_UNIT_READY: decStatus = ST_GOOD;
        OP_SENSE, OP_IDENTIFY, OP_PAGE_GET: begin
          kindRaw  = NX_DATA_IN;
          decCount = CNT_W'(cmdBuf[4]);
        end
        OP_READ_SHORT: begin
          kindRaw  = NX_DATA_IN;
          decCount = CNT_W'(cmdBuf[4]) << BLK_SHIFT;
        end
        OP_PAGE_SET: begin
          kindRaw  = NX_DATA_OUT;
          decCount = CNT_W'(cmdBuf[4]);
        end
        default: ;
      endcase
    end else if (at10) begin
      case (opcode)
        OP_SIZE: begin
          kindRaw  = NX_DATA_IN;
          decCount = CNT_W'(8);
        end
        OP_READ_LONG: begin
          kindRaw  = NX_DATA_IN;
          decCount = CNT_W'({cmdBuf[7], cmdBuf[8]}) << BLK_SHIFT;
          decLba   = LBA_W'({cmdBuf[2], cmdBuf[3], cmdBuf[4], cmdBuf[5]});
        end
        default: ;
      endcase
    end
    if (kindRaw != NX_STATUS) decStatus = ST_GOOD;
    // an empty transfer skips the data phase
    decKind = (decCount == '0) ? NX_STATUS : kindRaw;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdLen <= '0;
      for (int i = 0; i < CMD_MAX; i++) cmdBuf[i] <= '0;
    end else if (ctl.clrLen) begin
      cmdLen <= '0;
    end else if (ctl.pushByte && cmdLen < LEN_W'(CMD_MAX)) begin
      for (int i = 0; i < CMD_MAX; i++)
        if (cmdLen == LEN_W'(i)) cmdBuf[i] <= dataIn;
      cmdLen <= cmdLen + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntRem     <= '0;
      byteOfs    <= '0;
      blkAddr    <= '0;
      statusByte <= ST_GOOD;
    end else if (ctl.loadXfer) begin
      cntRem     <= decCount;
      byteOfs    <= '0;
      blkAddr    <= decLba;
      statusByte <= decStatus;
    end else if (ctl.stepXfer) begin
      cntRem  <= cntRem - 1'b1;
      byteOfs <= byteOfs + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataReg <= '0;
    else if (ctl.showSrc)     dataReg <= srcData;
    else if (ctl.showStatus)  dataReg <= statusByte;
    else if (ctl.showZero)    dataReg <= '0;
  end

  assign cntLast = (cntRem == CNT_W'(1));
  assign dataOut = dataReg;
  assign srcAddr = ({{BLK_SHIFT{1'b0}}, blkAddr} << BLK_SHIFT) + ADDR_W'(byteOfs);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepXfer |-> (cntRem != '0)) else $error("count stepped at zero"); // R8
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pushByte |-> (cmdLen < LEN_W'(CMD_MAX))) else $error("command overrun"); // R4

endmodule

// File: rtl/scsi_tgt_ctrl.sv
module scsi_tgt_ctrl
  import scsi_tgt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busRst,
  input  logic      selIn,
  input  logic      bsyIn,
  input  logic      atnIn,
  input  logic      ackIn,
  input  logic      dataEnIn,
  input  logic      idBit,
  input  logic      dmaEn,
  input  logic      dackIn,
  input  logic      decReady,
  input  nextKind_e decKind,
  input  logic      cntLast,
  output dpCtl_t    ctl,
  output logic      tgtBsy,
  output logic      msgOut,
  output logic      cdOut,
  output logic      ioOut,
  output logic      reqOut,
  output logic      drqOut
);

  phase_e phase;

  always_comb begin
    ctl = '0;
    if (!busRst) begin
      case (phase)
        PH_SELECT:  ctl.clrLen = 1'b1;
        PH_MSG_OUT: ctl.clrLen = reqOut && ackIn;
        PH_CMD: begin
          if (decReady)              ctl.loadXfer = 1'b1;
          else if (reqOut && ackIn)  ctl.pushByte = 1'b1;
        end
        PH_DATA_IN, PH_DATA_OUT: begin
          if (dmaEn) begin
            if (!dackIn)     ctl.showSrc  = (phase == PH_DATA_IN);
            else if (drqOut) ctl.stepXfer = 1'b1;
          end
        end
        PH_STATUS: ctl.showStatus = !ackIn;
        PH_MSG_IN: ctl.showZero   = !ackIn;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_FREE;
      tgtBsy <= 1'b0;
      {msgOut, cdOut, ioOut} <= 3'b000;
      reqOut <= 1'b0;
      drqOut <= 1'b0;
    end else if (busRst) begin
      phase  <= PH_FREE;
      tgtBsy <= 1'b0;
      {msgOut, cdOut, ioOut} <= 3'b000;
      reqOut <= 1'b0;
      drqOut <= 1'b0;
    end else begin
      case (phase)
        PH_FREE: if (selIn) phase <= PH_ARB;
        PH_ARB: begin
          if (!bsyIn && selIn && dataEnIn && idBit) begin
            phase  <= PH_SELECT;
            tgtBsy <= 1'b1;
          end else if (!bsyIn && !selIn) begin
            phase <= PH_FREE;
          end
        end
        PH_SELECT: begin
          if (atnIn) begin
            phase <= PH_MSG_OUT;
            {msgOut, cdOut, ioOut} <= 3'b110;
            reqOut <= 1'b1;
          end else begin
            phase <= PH_CMD;
            {msgOut, cdOut, ioOut} <= 3'b010;
          end
        end
        PH_MSG_OUT: begin
          if (reqOut && ackIn) begin
            reqOut <= 1'b0;
            phase  <= PH_CMD;
            {msgOut, cdOut, ioOut} <= 3'b010;
          end
        end
        PH_CMD: begin
          if (decReady) begin
            reqOut <= 1'b0;
            case (decKind)
              NX_DATA_IN: begin
                phase <= PH_DATA_IN;
                {msgOut, cdOut, ioOut} <= 3'b001;
              end
              NX_DATA_OUT: begin
                phase <= PH_DATA_OUT;
                {msgOut, cdOut, ioOut} <= 3'b000;
              end
              default: begin
                phase <= PH_STATUS;
                {msgOut, cdOut, ioOut} <= 3'b011;
              end
            endcase
          end else if (!ackIn) begin
            reqOut <= 1'b1;
          end else if (reqOut) begin
            reqOut <= 1'b0;
          end
        end
        PH_DATA_IN, PH_DATA_OUT: begin
          if (!ackIn) reqOut <= 1'b1;
          if (!dmaEn) begin
            drqOut <= 1'b0;
          end else if (!dackIn) begin
            drqOut <= 1'b1;
          end else if (drqOut) begin
            drqOut <= 1'b0;
            if (cntLast) begin
              reqOut <= 1'b0;
              phase  <= PH_STATUS;
              {msgOut, cdOut, ioOut} <= 3'b011;
            end
          end
        end
        PH_STATUS: begin
          if (!ackIn) begin
            reqOut <= 1'b1;
          end else if (reqOut) begin
            reqOut <= 1'b0;
            phase  <= PH_MSG_IN;
            {msgOut, cdOut, ioOut} <= 3'b111;
          end
        end
        PH_MSG_IN: begin
          if (!ackIn) begin
            reqOut <= 1'b1;
          end else if (reqOut) begin
            reqOut <= 1'b0;
            tgtBsy <= 1'b0;
            phase  <= PH_FREE;
            {msgOut, cdOut, ioOut} <= 3'b000;
          end
        end
        default: phase <= PH_FREE;
      endcase
    end
  end

  AST_RST_FREE: assert property (@(posedge clk) disable iff (!rstN)
    busRst |=> (!tgtBsy && !reqOut && !drqOut && phase == PH_FREE))
    else $error("bus reset not honoured"); // R1
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN || busRst)
    (reqOut && ackIn && (phase == PH_CMD || phase == PH_MSG_OUT ||
                         phase == PH_STATUS || phase == PH_MSG_IN)) |=> !reqOut)
    else $error("REQ held after ACK"); // R4
  AST_DRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEn |=> !drqOut) else $error("DRQ without DMA enable"); // R8
  AST_REQ_WITH_BSY: assert property (@(posedge clk) disable iff (!rstN)
    reqOut |-> tgtBsy) else $error("REQ while not busy"); // R9
  AST_SRC_DIR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.showSrc |-> (ioOut && !cdOut && !msgOut)) else $error("source read outside data-in"); // R12

endmodule

// File: rtl/scsi_target_sequencer.sv
module scsi_target_sequencer
  import scsi_tgt_pkg::*;
#(
  parameter int LBA_W     = 32,
  parameter int BLK_SHIFT = 9,
  parameter int CMD_MAX   = 10,
  localparam int CNT_W    = 16 + BLK_SHIFT,
  localparam int ADDR_W   = LBA_W + BLK_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRst,
  input  logic              selIn,
  input  logic              bsyIn,
  input  logic              atnIn,
  input  logic              ackIn,
  input  logic              dataEnIn,
  input  logic [7:0]        dataIn,
  input  logic              dmaEn,
  input  logic              dackIn,
  input  logic [7:0]        srcData,
  output logic              tgtBsy,
  output logic              msgOut,
  output logic              cdOut,
  output logic              ioOut,
  output logic              reqOut,
  output logic              drqOut,
  output logic [7:0]        dataOut,
  output logic              srcRd,
  output logic [ADDR_W-1:0] srcAddr
);

  dpCtl_t    ctl;
  logic      decReady;
  nextKind_e decKind;
  logic      cntLast;

  scsi_tgt_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busRst   (busRst),
    .selIn    (selIn),
    .bsyIn    (bsyIn),
    .atnIn    (atnIn),
    .ackIn    (ackIn),
    .dataEnIn (dataEnIn),
    .idBit    (dataIn[6]),
    .dmaEn    (dmaEn),
    .dackIn   (dackIn),
    .decReady (decReady),
    .decKind  (decKind),
    .cntLast  (cntLast),
    .ctl      (ctl),
    .tgtBsy   (tgtBsy),
    .msgOut   (msgOut),
    .cdOut    (cdOut),
    .ioOut    (ioOut),
    .reqOut   (reqOut),
    .drqOut   (drqOut)
  );

  scsi_tgt_dpath #(
    .LBA_W     (LBA_W),
    .BLK_SHIFT (BLK_SHIFT),
    .CMD_MAX   (CMD_MAX),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .dataIn   (dataIn),
    .srcData  (srcData),
    .decReady (decReady),
    .decKind  (decKind),
    .cntLast  (cntLast),
    .dataOut  (dataOut),
    .srcAddr  (srcAddr)
  );

  assign srcRd = ctl.showSrc;

endmodule

// File: tb/test_scsi_target_sequencer.sv
`timescale 1ns/1ps
module test_scsi_target_sequencer;

  localparam int AW = 41;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busRst = 1'b0, selIn = 1'b0, bsyIn = 1'b0, atnIn = 1'b0, ackIn = 1'b0;
  logic dataEnIn = 1'b0, dmaEn = 1'b1, dackIn = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] srcData;
  logic tgtBsy, msgOut, cdOut, ioOut, reqOut, drqOut, srcRd;
  logic [7:0] dataOut;
  logic [AW-1:0] srcAddr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mdl(input logic [AW-1:0] a);
    return a[7:0] ^ a[16:9] ^ a[40:33] ^ 8'h5A;
  endfunction

  assign srcData = mdl(srcAddr);

  scsi_target_sequencer i_scsi_target_sequencer (
    .clk(clk), .rstN(rstN), .busRst(busRst), .selIn(selIn), .bsyIn(bsyIn),
    .atnIn(atnIn), .ackIn(ackIn), .dataEnIn(dataEnIn), .dataIn(dataIn),
    .dmaEn(dmaEn), .dackIn(dackIn), .srcData(srcData), .tgtBsy(tgtBsy),
    .msgOut(msgOut), .cdOut(cdOut), .ioOut(ioOut), .reqOut(reqOut),
    .drqOut(drqOut), .dataOut(dataOut), .srcRd(srcRd), .srcAddr(srcAddr)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] lines();
    return {msgOut, cdOut, ioOut};
  endfunction

  task automatic waitReq();
    for (int i = 0; i < 40; i++) begin
      if (reqOut) break;
      @(negedge clk);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input string tag);
    waitReq();
    check(reqOut, {tag, " REQ for byte"}, reqOut, 1);
    dataIn = b;
    ackIn  = 1'b1;
    @(negedge clk);
    check(!reqOut, "R4 REQ drops on accept", reqOut, 0);
    ackIn  = 1'b0;
    dataIn = 8'h00;
  endtask

  task automatic selectTarget(input bit withAtn);
    @(negedge clk);
    selIn = 1'b1; dataEnIn = 1'b1; dataIn = 8'h41; atnIn = withAtn;
    @(negedge clk);
    check(!tgtBsy, "R2 busy after one edge", tgtBsy, 0);
    @(negedge clk);
    check(tgtBsy, "R2 busy after two edges", tgtBsy, 1);
    selIn = 1'b0; dataEnIn = 1'b0; dataIn = 8'h00;
    @(negedge clk);
    if (withAtn) begin
      check(lines() == 3'b110 && reqOut, "R3 message-out lines+REQ", {reqOut, lines()}, 4'b1110);
      sendByte(8'hC0, "R3");
      check(lines() == 3'b010, "R3 command after message", lines(), 3'b010);
      atnIn = 1'b0;
    end else begin
      check(lines() == 3'b010, "R3 command without attention", lines(), 3'b010);
    end
  endtask

  task automatic sendCmd(input logic [7:0] c [10], input int n);
    for (int i = 0; i < n; i++) sendByte(c[i], "R4");
    @(negedge clk);
  endtask

  task automatic dmaXfer(input int n, input bit isIn, input logic [AW-1:0] base,
                         input bit checkEnd, input string tag);
    int bad = 0;
    logic [7:0] firstAct = 0, firstExp = 0;
    bit srcSeen = 0;
    for (int i = 0; i < n; i++) begin
      for (int w = 0; w < 40; w++) begin
        if (drqOut) break;
        if (srcRd && !isIn) srcSeen = 1;
        @(negedge clk);
      end
      if (!drqOut) begin
        check(0, {tag, " DRQ missing"}, i, n);
        return;
      end
      if (srcRd && !isIn) srcSeen = 1;
      if (isIn && dataOut != mdl(base + AW'(i))) begin
        if (bad == 0) begin firstAct = dataOut; firstExp = mdl(base + AW'(i)); end
        bad++;
      end
      dackIn = 1'b1;
      @(negedge clk);
      check(!drqOut, "R8 DRQ drops after DACK", drqOut, 0);
      dackIn = 1'b0;
    end
    if (isIn) check(bad == 0, {tag, " data bytes"}, firstAct, firstExp);
    else      check(!srcSeen, "R12 no source read in data-out", srcSeen, 0);
    if (checkEnd) check(lines() == 3'b011, "R8 status after last byte", lines(), 3'b011);
  endtask

  task automatic finishCmd(input logic [7:0] st, input string tag);
    waitReq();
    check(reqOut && lines() == 3'b011 && dataOut == st, {tag, " status byte"},
          {reqOut, lines(), dataOut}, {1'b1, 3'b011, st});
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    waitReq();
    check(reqOut && lines() == 3'b111 && dataOut == 8'h00, "R9 message-in byte",
          {reqOut, lines(), dataOut}, {1'b1, 3'b111, 8'h00});
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    check(!tgtBsy && lines() == 3'b000, "R9 bus released", {tgtBsy, lines()}, 4'b0000);
  endtask

  task automatic runCmd(input bit withAtn, input logic [7:0] c [10], input int n,
                        input int kind, input int cnt, input logic [AW-1:0] base,
                        input logic [7:0] st, input string tag);
    selectTarget(withAtn);
    sendCmd(c, n);
    case (kind)
      1: check(lines() == 3'b001, {tag, " data-in lines"}, lines(), 3'b001);
      2: check(lines() == 3'b000, {tag, " data-out lines"}, lines(), 3'b000);
      default: check(lines() == 3'b011, {tag, " status lines"}, lines(), 3'b011);
    endcase
    if (kind != 0) dmaXfer(cnt, kind == 1, base, 1'b1, tag);
    finishCmd(st, tag);
  endtask

  // scenario tasks
  task automatic t_reset();
    check(!tgtBsy && !reqOut && !drqOut && lines() == 3'b000, "R1 reset state",
          {tgtBsy, reqOut, drqOut, lines()}, 0);
  endtask

  task automatic t_noId();
    bit seen = 0;
    @(negedge clk);
    selIn = 1'b1; dataEnIn = 1'b1; dataIn = 8'h01;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (tgtBsy) seen = 1;
    end
    check(!seen, "R2 no busy without ID bit", seen, 0);
    selIn = 1'b0; dataEnIn = 1'b0; dataIn = 8'h00;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_dmaGate();
    bit seen = 0;
    dmaEn = 1'b0;
    selectTarget(1'b0);
    sendCmd('{8'h12, 0, 0, 0, 8'h02, 0, 0, 0, 0, 0}, 6);
    check(lines() == 3'b001, "R5 data-in lines", lines(), 3'b001);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (drqOut) seen = 1;
    end
    check(!seen, "R8 no DRQ while DMA disabled", seen, 0);
    dmaEn = 1'b1;
    dmaXfer(2, 1'b1, '0, 1'b1, "R8");
    finishCmd(8'h00, "R8");
  endtask

  task automatic t_busReset();
    bit seen = 0;
    selectTarget(1'b0);
    sendCmd('{8'h28, 0, 0, 0, 0, 8'h01, 0, 0, 8'h01, 0}, 10);
    dmaXfer(3, 1'b1, AW'(512), 1'b0, "R6");
    busRst = 1'b1; selIn = 1'b1; dataEnIn = 1'b1; dataIn = 8'h41;
    @(negedge clk);
    check(!tgtBsy && !reqOut && !drqOut && lines() == 3'b000, "R1 bus reset mid-transfer",
          {tgtBsy, reqOut, drqOut, lines()}, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (tgtBsy) seen = 1;
    end
    check(!seen, "R1 reset overrides selection", seen, 0);
    busRst = 1'b0; selIn = 1'b0; dataEnIn = 1'b0; dataIn = 8'h00;
    @(negedge clk);
    runCmd(1'b0, '{8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 6, 0, 0, '0, 8'h00, "R1 recovery");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_noId();
    runCmd(1'b0, '{8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 6, 0, 0, '0, 8'h00, "R5 unit-ready");
    runCmd(1'b1, '{8'h00, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 6, 0, 0, '0, 8'h00, "R3 with attention");
    runCmd(1'b0, '{8'h12, 0, 0, 0, 8'h05, 0, 0, 0, 0, 0}, 6, 1, 5, '0, 8'h00, "R5 opcode 12");
    runCmd(1'b0, '{8'h03, 0, 0, 0, 8'h03, 0, 0, 0, 0, 0}, 6, 1, 3, '0, 8'h00, "R5 opcode 03");
    runCmd(1'b1, '{8'h1A, 0, 0, 0, 8'h02, 0, 0, 0, 0, 0}, 6, 1, 2, '0, 8'h00, "R5 opcode 1A");
    runCmd(1'b0, '{8'h15, 0, 0, 0, 8'h04, 0, 0, 0, 0, 0}, 6, 2, 4, '0, 8'h00, "R5 opcode 15");
    runCmd(1'b0, '{8'h08, 0, 0, 0, 8'h01, 0, 0, 0, 0, 0}, 6, 1, 512, '0, 8'h00, "R6 short read");
    runCmd(1'b0, '{8'h28, 0, 8'h02, 0, 0, 8'h03, 0, 0, 8'h01, 0}, 10, 1, 512,
           (AW'(32'h0200_0003) << 9), 8'h00, "R6 long read");
    runCmd(1'b0, '{8'h25, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 10, 1, 8, '0, 8'h00, "R7 size query");
    runCmd(1'b0, '{8'h05, 0, 0, 0, 8'h07, 0, 0, 0, 0, 0}, 6, 0, 0, '0, 8'h02, "R10 unknown group 0");
    runCmd(1'b1, '{8'h2A, 0, 0, 0, 0, 0, 0, 0, 8'h01, 0}, 10, 0, 0, '0, 8'h02, "R10 unknown group 1");
    runCmd(1'b0, '{8'hE0, 0, 0, 0, 8'h01, 0, 0, 0, 0, 0}, 6, 0, 0, '0, 8'h02, "R10 unknown group 7");
    runCmd(1'b0, '{8'h12, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0}, 6, 0, 0, '0, 8'h00, "R11 zero count");
    runCmd(1'b0, '{8'h28, 0, 0, 0, 0, 8'h09, 0, 0, 8'h00, 0}, 10, 0, 0, '0, 8'h00, "R11 zero blocks");
    t_dmaGate();
    t_busReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1..: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule